// File: doc/BRIEF.md
# Flow Expiry Timeout Scanner

This block runs a continuous background sweep over a flow table that an updater maintains at line rate. It reads one entry at a time through the table's second port. A busy entry is judged against two independent limits. The first is idle time: the current tick minus the time the entry was last seen. The second is lifetime: the current tick minus the time the entry was created. When either age is strictly larger than its limit, the scanner offers the entry's contents as an export record. It clears the entry's busy bit in the same cycle that the record is accepted.

The updater owns the table's first port. The scanner watches the updater's write strobe and address. Any write to the entry the scanner is working on makes the scanner's copy stale. The scanner then withdraws its offer, reads the entry again and judges it afresh. Because of this, a record never leaves with old contents, and the updater's data is never overwritten by a clear. Both limits are given in time-counter ticks and are captured while reset is asserted. All ages are computed modulo 2^TW, so a wrap of the time counter does not make a flow look old.

Top module: `flow_expiry_scanner`

## Requirements
- R1: While reset is low and in the first cycle after it, `exp_valid` and `tbl_clr_en` are 0, `tbl_rd_en` is 1 and `tbl_addr` is 0.
- R2: `tbl_addr` changes only by stepping to the next entry, and it wraps from DEPTH-1 to 0. Every entry is read in every sweep.
- R3: An entry read with `tbl_rd_busy` = 0 is never exported and is never cleared.
- R4: A busy entry whose idle age, (`now_tick` - stored last-seen time) mod 2^TW, is strictly greater than the idle limit is exported with `exp_why` bit 0 set. An idle age equal to the limit does not expire the entry.
- R5: A busy entry whose lifetime, (`now_tick` - stored creation time) mod 2^TW, is strictly greater than the lifetime limit is exported with `exp_why` bit 1 set, whatever its recent activity. When both rules hold, both bits are set.
- R6: Ages are taken modulo 2^TW. A stored time numerically larger than `now_tick` (because the counter has wrapped) yields a small age and causes no false expiry.
- R7: The limits are sampled from `cfg_idle_lim` and `cfg_life_lim` only while reset is low. Changes to these inputs after reset have no effect.
- R8: While `exp_ready` is 0, the offered record (`exp_addr`, `exp_first`, `exp_last`, `exp_info`, `exp_why`) stays stable, the scan does not advance and the entry stays busy.
- R9: `tbl_clr_en` is asserted, at `tbl_addr`, only in a cycle where `exp_valid` and `exp_ready` are both 1.
- R10: In any cycle where `upd_wr_en` is set with `upd_addr` equal to the entry in work, `exp_valid` is 0 and no clear is issued. The entry is then read again before any export, so the updater's contents survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the limits are captured while it is low |
| now_tick | input | TW | Current time-counter value |
| cfg_idle_lim | input | TW | Idle limit in ticks, sampled during reset |
| cfg_life_lim | input | TW | Lifetime limit in ticks, sampled during reset |
| tbl_rd_en | output | 1 | Read strobe to the table's second port |
| tbl_addr | output | AW | Entry index for reads and clears |
| tbl_rd_busy | input | 1 | Busy bit of the entry, one cycle after the read |
| tbl_rd_first | input | TW | Creation time of the entry, one cycle after the read |
| tbl_rd_last | input | TW | Last-seen time of the entry, one cycle after the read |
| tbl_rd_info | input | IW | Flow contents carried into the record |
| tbl_clr_en | output | 1 | Clear the busy bit at `tbl_addr` |
| upd_wr_en | input | 1 | The updater writes the table on the first port this cycle |
| upd_addr | input | AW | Entry index the updater writes |
| exp_valid | output | 1 | Export record offered |
| exp_ready | input | 1 | Export side accepts the record |
| exp_addr | output | AW | Entry index of the record |
| exp_first | output | TW | Creation time of the record |
| exp_last | output | TW | Last-seen time of the record |
| exp_info | output | IW | Flow contents of the record |
| exp_why | output | 2 | Cause: bit 0 idle, bit 1 lifetime |

## Verification
The bench places entries exactly at the idle limit and one tick beyond it. A comparison written with >= instead of > would evict the entry that sits at the limit. It also places entries whose stored times lie just before a counter wrap; a non-modular subtraction would report these as hugely old. A long stall on the export side would catch an early clear or a drifting record. An updater write that lands on the held entry would catch a design that keeps offering stale contents or lets its clear destroy the fresh write. Changing the limit inputs after reset would catch limits that are read live.

// File: rtl/fes_pkg.sv
package fes_pkg;
   typedef enum logic [1:0] {
      ST_ISSUE = 2'd0,
      ST_EVAL  = 2'd1,
      ST_HOLD  = 2'd2
   } scan_st_e;

   localparam int CAUSE_IDLE = 0;
   localparam int CAUSE_LIFE = 1;
endpackage

// File: rtl/fes_limit_regs.sv
module fes_limit_regs #(
   parameter int TW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] cfg_idle,
   input  logic [TW-1:0] cfg_life,
   output logic [TW-1:0] idle_lim,
   output logic [TW-1:0] life_lim
);
   // limits follow the inputs only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_lim <= cfg_idle;
         life_lim <= cfg_life;
      end
   end
endmodule

// File: rtl/fes_addr_walker.sv
module fes_addr_walker #(
   parameter int DEPTH = 4096,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n)    addr <= '0;
            else if (step) addr <= addr + 1'b1;
         end
      end else begin : g_odd
         always_ff @(posedge clk) begin
            if (!rst_n)    addr <= '0;
            else if (step) addr <= (addr == LAST) ? '0 : addr + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/fes_age_judge.sv
module fes_age_judge #(
   parameter int TW = 32
) (
   input  logic [TW-1:0] now_tick,
   input  logic [TW-1:0] first_ts,
   input  logic [TW-1:0] last_ts,
   input  logic [TW-1:0] idle_lim,
   input  logic [TW-1:0] life_lim,
   output logic [1:0]    why
);
   logic [TW-1:0] idle_age;
   logic [TW-1:0] life_age;

   // modular differences: a wrapped counter still yields the true distance
   always_comb begin
      idle_age = now_tick - last_ts;
      life_age = now_tick - first_ts;
      why[fes_pkg::CAUSE_IDLE] = idle_age > idle_lim;
      why[fes_pkg::CAUSE_LIFE] = life_age > life_lim;
   end
endmodule

// File: rtl/flow_expiry_scanner.sv
module flow_expiry_scanner
   import fes_pkg::*;
#(
   parameter int DEPTH = 4096,
   parameter int TW    = 32,
   parameter int IW    = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] now_tick,
   input  logic [TW-1:0] cfg_idle_lim,
   input  logic [TW-1:0] cfg_life_lim,
   output logic          tbl_rd_en,
   output logic [AW-1:0] tbl_addr,
   input  logic          tbl_rd_busy,
   input  logic [TW-1:0] tbl_rd_first,
   input  logic [TW-1:0] tbl_rd_last,
   input  logic [IW-1:0] tbl_rd_info,
   output logic          tbl_clr_en,
   input  logic          upd_wr_en,
   input  logic [AW-1:0] upd_addr,
   output logic          exp_valid,
   input  logic          exp_ready,
   output logic [AW-1:0] exp_addr,
   output logic [TW-1:0] exp_first,
   output logic [TW-1:0] exp_last,
   output logic [IW-1:0] exp_info,
   output logic [1:0]    exp_why
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("flow_expiry_scanner: DEPTH must be at least 2");
      end
      if (TW < 2) begin : g_bad_tw
         $error("flow_expiry_scanner: TW must be at least 2");
      end
      if (IW < 1) begin : g_bad_iw
         $error("flow_expiry_scanner: IW must be at least 1");
      end
   endgenerate

   scan_st_e      state, state_nx;
   logic [AW-1:0] scan_addr;
   logic [TW-1:0] idle_lim, life_lim;
   logic [1:0]    why;
   logic          collide, expired, step;

   fes_limit_regs #(.TW(TW)) u_limits (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_idle (cfg_idle_lim),
      .cfg_life (cfg_life_lim),
      .idle_lim (idle_lim),
      .life_lim (life_lim)
   );

   fes_addr_walker #(.DEPTH(DEPTH)) u_walker (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .addr  (scan_addr)
   );

   fes_age_judge #(.TW(TW)) u_judge (
      .now_tick (now_tick),
      .first_ts (tbl_rd_first),
      .last_ts  (tbl_rd_last),
      .idle_lim (idle_lim),
      .life_lim (life_lim),
      .why      (why)
   );

   // updater touching the entry in work invalidates the scanner's copy
   assign collide = upd_wr_en && (upd_addr == scan_addr);
   assign expired = tbl_rd_busy && (why != 2'b00);

   always_comb begin
      state_nx   = state;
      step       = 1'b0;
      tbl_rd_en  = 1'b0;
      exp_valid  = 1'b0;
      tbl_clr_en = 1'b0;
      unique case (state)
         ST_ISSUE: begin
            tbl_rd_en = 1'b1;
            if (!collide) state_nx = ST_EVAL;
         end
         ST_EVAL: begin
            if (collide) begin
               state_nx = ST_ISSUE;
            end else if (expired) begin
               state_nx = ST_HOLD;
            end else begin
               step     = 1'b1;
               state_nx = ST_ISSUE;
            end
         end
         ST_HOLD: begin
            if (collide) begin
               state_nx = ST_ISSUE;
            end else begin
               exp_valid = 1'b1;
               if (exp_ready) begin
                  tbl_clr_en = 1'b1;
                  step       = 1'b1;
                  state_nx   = ST_ISSUE;
               end
            end
         end
         default: state_nx = ST_ISSUE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_ISSUE;
      else        state <= state_nx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_first <= '0;
         exp_last  <= '0;
         exp_info  <= '0;
         exp_why   <= '0;
      end else if (state == ST_EVAL && !collide && expired) begin
         exp_first <= tbl_rd_first;
         exp_last  <= tbl_rd_last;
         exp_info  <= tbl_rd_info;
         exp_why   <= why;
      end
   end

   assign tbl_addr = scan_addr;
   assign exp_addr = scan_addr;
endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
   parameter int DEPTH = 4096,
   parameter int TW    = 32,
   parameter int IW    = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] tbl_addr,
   input logic          tbl_clr_en,
   input logic          upd_wr_en,
   input logic [AW-1:0] upd_addr,
   input logic          exp_valid,
   input logic          exp_ready,
   input logic [AW-1:0] exp_addr,
   input logic [TW-1:0] exp_first,
   input logic [TW-1:0] exp_last,
   input logic [IW-1:0] exp_info,
   input logic [1:0]    exp_why
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   logic [AW-1:0] prev_addr;
   logic [AW-1:0] next_addr;

   always_ff @(posedge clk) prev_addr <= tbl_addr;
   assign next_addr = (prev_addr == LAST) ? '0 : prev_addr + 1'b1;

   p_sweep_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_addr != prev_addr) |-> (tbl_addr == next_addr));

   p_offer_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      exp_valid |-> (exp_why != 2'b00));

   p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_valid && !exp_ready) |=> (!exp_valid ||
         ($stable(exp_addr) && $stable(exp_first) && $stable(exp_last) &&
          $stable(exp_info) && $stable(exp_why))));

   p_clear_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_clr_en |-> (exp_valid && exp_ready && exp_addr == tbl_addr));

   p_no_stale_offer_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_wr_en && upd_addr == exp_addr) |-> (!exp_valid && !tbl_clr_en));
endmodule

bind flow_expiry_scanner fes_checker #(.DEPTH(DEPTH), .TW(TW), .IW(IW)) u_fes_chk (.*);

// File: tb/flow_expiry_scanner_test.sv
`timescale 1ns/1ps
module flow_expiry_scanner_test;
   localparam int DEPTH = 16;
   localparam int TW    = 16;
   localparam int IW    = 8;
   localparam int AW    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [TW-1:0] now_tick = '0, cfg_idle_lim = '0, cfg_life_lim = '0;
   logic tbl_rd_en, tbl_clr_en, tbl_rd_busy = 1'b0;
   logic [AW-1:0] tbl_addr;
   logic [TW-1:0] tbl_rd_first = '0, tbl_rd_last = '0;
   logic [IW-1:0] tbl_rd_info = '0;
   logic upd_wr_en = 1'b0, upd_busy = 1'b0;
   logic [AW-1:0] upd_addr = '0;
   logic [TW-1:0] upd_first = '0, upd_last = '0;
   logic [IW-1:0] upd_info = '0;
   logic exp_valid, exp_ready = 1'b1;
   logic [AW-1:0] exp_addr;
   logic [TW-1:0] exp_first, exp_last;
   logic [IW-1:0] exp_info;
   logic [1:0] exp_why;

   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   flow_expiry_scanner #(.DEPTH(DEPTH), .TW(TW), .IW(IW)) uut (.*);

   // table model: port A updater (wins), port B read-first + clear
   logic m_busy [DEPTH];
   logic [TW-1:0] m_first [DEPTH], m_last [DEPTH];
   logic [IW-1:0] m_info [DEPTH];
   logic q_rd, q_clr, q_uw, q_ub;
   logic [AW-1:0] q_addr, q_ua;
   logic [TW-1:0] q_uf, q_ul;
   logic [IW-1:0] q_ui;

   always @(negedge clk) begin
      q_rd <= tbl_rd_en; q_clr <= tbl_clr_en; q_addr <= tbl_addr;
      q_uw <= upd_wr_en; q_ua <= upd_addr; q_ub <= upd_busy;
      q_uf <= upd_first; q_ul <= upd_last; q_ui <= upd_info;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) m_busy[i] <= 1'b0;
      end else begin
         if (q_rd) begin
            tbl_rd_busy  <= m_busy[q_addr];
            tbl_rd_first <= m_first[q_addr];
            tbl_rd_last  <= m_last[q_addr];
            tbl_rd_info  <= m_info[q_addr];
         end
         if (q_clr && !(q_uw && q_ua == q_addr)) m_busy[q_addr] <= 1'b0;
         if (q_uw) begin
            m_busy[q_ua] <= q_ub; m_first[q_ua] <= q_uf;
            m_last[q_ua] <= q_ul; m_info[q_ua] <= q_ui;
         end
      end
   end

   // export log and sweep-order monitor
   int lg_n = 0;
   logic [AW-1:0] lg_addr [64];
   logic [1:0]    lg_why [64];
   logic [TW-1:0] lg_last [64];
   logic [IW-1:0] lg_info [64];
   int order_bad = 0, wraps = 0;
   bit have_prev = 0;
   logic [AW-1:0] prev = '0;

   always @(negedge clk) begin
      if (rst_n && exp_valid && exp_ready && lg_n < 64) begin
         lg_addr[lg_n] = exp_addr; lg_why[lg_n] = exp_why;
         lg_last[lg_n] = exp_last; lg_info[lg_n] = exp_info;
         lg_n++;
      end
      if (rst_n && tbl_rd_en) begin
         if (have_prev && tbl_addr != prev) begin
            if (tbl_addr != AW'(prev + 1)) order_bad++;
            if (prev == AW'(DEPTH - 1) && tbl_addr == '0) wraps++;
         end
         prev = tbl_addr; have_prev = 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset(input int idle, input int life);
      rst_n = 1'b0; upd_wr_en = 1'b0; exp_ready = 1'b1;
      cfg_idle_lim = TW'(idle); cfg_life_lim = TW'(life);
      cyc(3);
      lg_n = 0; have_prev = 0; order_bad = 0; wraps = 0;
      rst_n = 1'b1;
   endtask

   task automatic wr(input int a, input bit b, input int f, input int l, input int inf);
      upd_wr_en = 1'b1; upd_addr = AW'(a); upd_busy = b;
      upd_first = TW'(f); upd_last = TW'(l); upd_info = IW'(inf);
      cyc(1);
      upd_wr_en = 1'b0;
   endtask

   function automatic int find(input int a);
      for (int i = 0; i < lg_n; i++) if (lg_addr[i] == AW'(a)) return i;
      return -1;
   endfunction

   task automatic t_reset();
      rst_n = 1'b0; cfg_idle_lim = 100; cfg_life_lim = 1000;
      cyc(3);
      chk(exp_valid == 0 && tbl_clr_en == 0, "R1", "quiet in reset", exp_valid, 0);
      rst_n = 1'b1; #1;
      chk(tbl_rd_en == 1 && tbl_addr == 0, "R1", "first read at entry 0", tbl_addr, 0);
      chk(exp_valid == 0, "R1", "no offer after reset", exp_valid, 0);
   endtask

   task automatic t_sweep();
      do_reset(100, 1000);
      now_tick = 5000;
      cyc(110);
      chk(order_bad == 0, "R2", "address steps by one", order_bad, 0);
      chk(wraps >= 2, "R2", "wrap from last to 0", wraps, 2);
      chk(lg_n == 0, "R3", "free entries not exported", lg_n, 0);
   endtask

   task automatic t_idle();
      do_reset(100, 1000);
      cfg_idle_lim = 5; cfg_life_lim = 5;
      now_tick = 5000;
      wr(3, 1, 4950, 4899, 33);
      wr(5, 1, 4950, 4900, 55);
      wr(6, 1, 4990, 4950, 66);
      cyc(120);
      chk(find(3) >= 0, "R4", "idle 101 exported", find(3), 0);
      if (find(3) >= 0) begin
         chk(lg_why[find(3)] == 2'b01, "R4", "idle cause", lg_why[find(3)], 1);
         chk(lg_info[find(3)] == 33 && lg_last[find(3)] == 4899, "R4", "record contents",
             lg_info[find(3)], 33);
      end
      chk(m_busy[3] == 0, "R9", "exported entry cleared", m_busy[3], 0);
      chk(find(5) < 0 && m_busy[5] == 1, "R4", "idle equal to limit kept", find(5), -1);
      chk(find(6) < 0, "R7", "limit changed after reset ignored", find(6), -1);
      chk(lg_n == 1, "R3", "single export", lg_n, 1);
   endtask

   task automatic t_life();
      do_reset(100, 1000);
      now_tick = 5000;
      wr(7, 1, 3999, 5000, 77);
      wr(8, 1, 4000, 5000, 88);
      wr(9, 1, 3000, 4000, 99);
      cyc(120);
      chk(find(7) >= 0 && lg_why[find(7) < 0 ? 0 : find(7)] == 2'b10, "R5",
          "lifetime 1001 exported with cause 2", find(7), 0);
      chk(find(8) < 0 && m_busy[8] == 1, "R5", "lifetime equal to limit kept", find(8), -1);
      chk(find(9) >= 0 && lg_why[find(9) < 0 ? 0 : find(9)] == 2'b11, "R5",
          "both causes", find(9), 0);
   endtask

   task automatic t_wrap();
      do_reset(100, 1000);
      now_tick = 20;
      wr(1, 1, 65530, 65530, 11);
      wr(2, 1, 65530, 65450, 22);
      cyc(120);
      chk(find(1) < 0 && m_busy[1] == 1, "R6", "wrapped stamp not expired", find(1), -1);
      chk(find(2) >= 0 && lg_why[find(2) < 0 ? 0 : find(2)] == 2'b01, "R6",
          "wrapped idle 106 expired", find(2), 0);
   endtask

   task automatic t_stall();
      do_reset(100, 1000);
      exp_ready = 1'b0;
      now_tick = 5000;
      wr(2, 1, 4990, 4800, 44);
      cyc(60);
      chk(exp_valid == 1 && exp_addr == 2, "R8", "offer held", exp_addr, 2);
      chk(tbl_addr == 2 && tbl_clr_en == 0, "R8", "scan stalled, no clear", tbl_addr, 2);
      chk(m_busy[2] == 1, "R8", "entry busy while stalled", m_busy[2], 1);
      cyc(20);
      chk(exp_last == 4800 && exp_info == 44 && exp_why == 2'b01, "R8", "record stable",
          exp_last, 4800);
      exp_ready = 1'b1;
      cyc(5);
      chk(find(2) >= 0 && m_busy[2] == 0, "R9", "cleared on accept", m_busy[2], 0);
   endtask

   task automatic t_collide();
      do_reset(100, 1000);
      exp_ready = 1'b0;
      now_tick = 5000;
      wr(4, 1, 4990, 4700, 12);
      cyc(60);
      chk(exp_valid == 1 && exp_addr == 4, "R10", "stale candidate held", exp_addr, 4);
      upd_wr_en = 1'b1; upd_addr = 4; upd_busy = 1'b1;
      upd_first = 4990; upd_last = 5000; upd_info = 34;
      #1;
      chk(exp_valid == 0, "R10", "offer withdrawn on updater write", exp_valid, 0);
      exp_ready = 1'b1; #1;
      chk(tbl_clr_en == 0, "R10", "no clear on updater write", tbl_clr_en, 0);
      cyc(1);
      upd_wr_en = 1'b0;
      cyc(100);
      chk(find(4) < 0, "R10", "refreshed entry not exported", find(4), -1);
      chk(m_busy[4] == 1 && m_last[4] == 5000, "R10", "updater data survives",
          m_last[4], 5000);
   endtask

   initial begin
      #(5.0 * 150000);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_sweep();
      t_idle();
      t_life();
      t_wrap();
      t_stall();
      t_collide();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule